// File: doc/BRIEF.md
# Two-channel positioned PCM shifter

This block moves two audio channels between 32-bit FIFO words and a serial data line. Each channel sits at its own bit position inside a frame of up to 1024 bits and has its own width, from 8 to 32 bits. A separate timing generator supplies the frame bit index, a frame-start strobe, a drive tick and a sample tick. The shifter only decides which bit belongs where. On transmit it pops words from a FIFO and drives `sdo` MSB first. On receive it samples `sdi` MSB first and pushes words into a FIFO.

Transmit and receive each take their own 32-bit channel configuration word and their own packed-mode flag. In unpacked mode every channel sample uses one FIFO word, right-aligned. In packed mode one word carries both channels as 16-bit halves. When the transmit FIFO is empty the block sends zeros. When the receive FIFO is full it drops the sample. In both cases it pulses an error flag. A channel placed at bit 0 while the frame sync comes from outside may land in the neighbouring frame, which swaps left and right. This is a known hazard and is not flagged.

Top module: `pcm_pos_shifter`

## Requirements
- R1: Each configuration word holds channel 1 in bits 31:16 and channel 2 in bits 15:0. Each half is laid out as: bit 15 width-extend, bit 14 channel enable, bits 13:4 the bit position in the frame (0..1023), bits 3:0 the width code.
- R2: Channel width is 8 + width code, plus 16 when width-extend is set. Any result above 32 is treated as 32.
- R3: A drive tick whose bit index equals an enabled transmit channel's position puts that sample's MSB on `sdo` at that tick's clock edge. The next width-1 drive ticks carry the remaining bits, MSB first. `sdo` is 0 on drive ticks that fall outside every channel and changes only on drive ticks.
- R4: Unpacked transmit pops one FIFO word, on the starting drive tick, for each enabled channel. Pops follow the order of position in the frame. Only the low width bits are sent; higher bits of the word are ignored. A pop happens only on a drive tick.
- R5: Packed transmit pops one word when `frame_start` is seen with either channel enabled. Channel 1 sends bits 15:0 of that word and channel 2 sends bits 31:16, each zero-extended to the channel width.
- R6: If a word is needed while the transmit FIFO is empty, no pop occurs and the sample is sent as zeros. `tx_err` is high for exactly the one cycle after that drive tick.
- R7: Receive samples `sdi` on the sample ticks from an enabled channel's position for width ticks, MSB first. In unpacked mode the word is pushed in the cycle after the last sample tick, right-aligned with zeros above the width.
- R8: In packed mode, channel 1's low 16 received bits go to bits 15:0 and channel 2's to bits 31:16. The word is pushed in the cycle after the next `frame_start`, provided a channel completed since the previous push. A half that was not captured reads 0.
- R9: If `rx_fifo_full` is high when a push would occur, the word is dropped and `rx_err` is high for that one cycle instead of `rx_fifo_push`.
- R10: A disabled channel causes no pop, no push and no `sdo` bit. With both channels disabled, `frame_start` pops nothing in packed mode.
- R11: After reset `sdo`, `rx_fifo_push`, `rx_fifo_data`, `tx_err` and `rx_err` are 0, and no pop occurs without a tick.
- R12: The block expects `drive_tick` and `sample_tick` never to be high in the same cycle, and `frame_start` to be high only together with `drive_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_tick | input | 1 | Bit boundary at which transmit data advances |
| sample_tick | input | 1 | Point at which receive data is sampled |
| frame_start | input | 1 | First-bit strobe of a frame, given with drive_tick |
| bit_idx | input | 10 | Index of the current bit within the frame |
| tx_cfg | input | 32 | Transmit channel configuration word |
| rx_cfg | input | 32 | Receive channel configuration word |
| tx_packed | input | 1 | Transmit packed-mode flag |
| rx_packed | input | 1 | Receive packed-mode flag |
| tx_fifo_data | input | 32 | Head word of the transmit FIFO |
| tx_fifo_empty | input | 1 | Transmit FIFO has no word |
| tx_fifo_pop | output | 1 | Consume the head word of the transmit FIFO |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rx_fifo_full | input | 1 | Receive FIFO cannot accept a word |
| rx_fifo_push | output | 1 | Write rx_fifo_data into the receive FIFO |
| rx_fifo_data | output | 32 | Received word |
| tx_err | output | 1 | One-cycle pulse on transmit underflow |
| rx_err | output | 1 | One-cycle pulse on a dropped receive word |

## Verification
Each transmit bit is due on `sdo` in the cycle right after the drive tick that carries it. The bench drives every tick at a falling edge and reads `sdo` and `tx_err` at the next falling edge, after exactly one register. An unpacked receive word appears on `rx_fifo_push` one cycle after the channel's last sample tick. A packed word appears one cycle after the following `frame_start`. A posedge monitor therefore collects pushes, and the bench waits two idle cycles after a frame before it compares the collected list with the list it predicts in frame order. Underflow and overflow flags are checked both by count and by the bit index at which they appear.

// File: rtl/pcm_shift_pkg.sv
package pcm_shift_pkg;
  localparam int WORD_W  = 32;   // FIFO word width
  localparam int HALF_W  = 16;   // one channel field / one packed sample
  localparam int POS_W   = 10;   // frame bit index width (frames up to 1024)
  localparam int CODE_W  = 4;    // width code
  localparam int WID_W   = 6;    // decoded width 8..32
  localparam int MIN_W   = 8;
  localparam int EXT_ADD = 16;
  localparam int NCH     = 2;
  localparam logic [WID_W:0] WORD_W_V = (WID_W+1)'(WORD_W);

  typedef struct packed {
    logic              ext;
    logic              en;
    logic [POS_W-1:0]  pos;
    logic [CODE_W-1:0] code;
  } chan_field_t;

  typedef struct packed {
    logic             en;
    logic [POS_W-1:0] pos;
    logic [WID_W-1:0] width;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_chan(input logic [HALF_W-1:0] half);
    chan_field_t f;
    logic [WID_W:0] w;
    chan_cfg_t r;
    f = chan_field_t'(half);
    w = (WID_W+1)'(MIN_W) + (WID_W+1)'(f.code)
      + (f.ext ? (WID_W+1)'(EXT_ADD) : (WID_W+1)'(0));
    if (w > WORD_W_V) w = WORD_W_V;
    r.en    = f.en;
    r.pos   = f.pos;
    r.width = w[WID_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [POS_W-1:0]  bit_idx,
  input  chan_cfg_t         cfg,
  input  logic [WORD_W-1:0] sample,
  output logic              start,
  output logic              bit_vld,
  output logic              bit_val
);
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] aligned;
  logic [WID_W-1:0]  rem;

  assign start   = cfg.en && tick && (bit_idx == cfg.pos);
  // move the sample's MSB (bit width-1) to the top; bits above width fall off
  assign aligned = sample << (WORD_W_V - {1'b0, cfg.width});
  assign bit_vld = start || (tick && (rem != '0));
  assign bit_val = start ? aligned[WORD_W-1] : sr[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      rem <= '0;
    end else if (start) begin
      sr  <= aligned << 1;
      rem <= cfg.width - WID_W'(1);
    end else if (tick && (rem != '0)) begin
      sr  <= sr << 1;
      rem <= rem - WID_W'(1);
    end
  end
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [POS_W-1:0]  bit_idx,
  input  chan_cfg_t         cfg,
  input  logic              sdi,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] acc;
  logic [WID_W-1:0]  rem;
  logic              start;

  assign start = cfg.en && tick && (bit_idx == cfg.pos);
  assign done  = tick && (rem == WID_W'(1));
  assign word  = {acc[WORD_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      rem <= '0;
    end else if (start) begin
      acc <= WORD_W'(sdi);
      rem <= cfg.width - WID_W'(1);
    end else if (tick && (rem != '0)) begin
      acc <= {acc[WORD_W-2:0], sdi};
      rem <= rem - WID_W'(1);
    end
  end
endmodule

// File: rtl/pcm_pos_shifter.sv
module pcm_pos_shifter
  import pcm_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              drive_tick,
  input  logic              sample_tick,
  input  logic              frame_start,
  input  logic [POS_W-1:0]  bit_idx,
  input  logic [WORD_W-1:0] tx_cfg,
  input  logic [WORD_W-1:0] rx_cfg,
  input  logic              tx_packed,
  input  logic              rx_packed,
  input  logic [WORD_W-1:0] tx_fifo_data,
  input  logic              tx_fifo_empty,
  output logic              tx_fifo_pop,
  output logic              sdo,
  input  logic              sdi,
  input  logic              rx_fifo_full,
  output logic              rx_fifo_push,
  output logic [WORD_W-1:0] rx_fifo_data,
  output logic              tx_err,
  output logic              rx_err
);
  chan_cfg_t         tcfg [NCH];
  chan_cfg_t         rcfg [NCH];
  logic [NCH-1:0]    t_start, t_vld, t_val, r_done;
  logic [WORD_W-1:0] t_sample [NCH];
  logic [WORD_W-1:0] r_word [NCH];
  logic [WORD_W-1:0] fifo_word, pk_word, pk_src, up_word;
  logic [HALF_W-1:0] pk_half [NCH];
  logic              pk_pop, need, pk_have, up_done, flush;

  assign fifo_word   = tx_fifo_empty ? '0 : tx_fifo_data;
  assign pk_pop      = tx_packed && frame_start && drive_tick && (tcfg[0].en || tcfg[1].en);
  assign need        = pk_pop || (!tx_packed && (|t_start));
  assign tx_fifo_pop = need && !tx_fifo_empty;
  assign pk_src      = pk_pop ? fifo_word : pk_word;

  // channel 1 in the upper half of the config word, channel 2 in the lower
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign tcfg[c]     = decode_chan(tx_cfg[WORD_W-1-c*HALF_W -: HALF_W]);
    assign rcfg[c]     = decode_chan(rx_cfg[WORD_W-1-c*HALF_W -: HALF_W]);
    assign t_sample[c] = tx_packed ? WORD_W'(pk_src[c*HALF_W +: HALF_W]) : fifo_word;

    pcm_tx_lane u_tx (
      .clk(clk), .rst(rst), .tick(drive_tick), .bit_idx(bit_idx), .cfg(tcfg[c]),
      .sample(t_sample[c]), .start(t_start[c]), .bit_vld(t_vld[c]), .bit_val(t_val[c])
    );
    pcm_rx_lane u_rx (
      .clk(clk), .rst(rst), .tick(sample_tick), .bit_idx(bit_idx), .cfg(rcfg[c]),
      .sdi(sdi), .done(r_done[c]), .word(r_word[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo     <= 1'b0;
      tx_err  <= 1'b0;
      pk_word <= '0;
    end else begin
      tx_err <= need && tx_fifo_empty;
      if (pk_pop) pk_word <= pk_src;
      if (drive_tick) sdo <= t_vld[0] ? t_val[0] : (t_vld[1] && t_val[1]);
    end
  end

  assign up_done = !rx_packed && (|r_done);
  assign up_word = r_done[0] ? r_word[0] : r_word[1];
  assign flush   = rx_packed && frame_start && pk_have;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_fifo_push <= 1'b0;
      rx_fifo_data <= '0;
      rx_err       <= 1'b0;
      pk_have      <= 1'b0;
      for (int c = 0; c < NCH; c++) pk_half[c] <= '0;
    end else begin
      rx_fifo_push <= (up_done || flush) && !rx_fifo_full;
      rx_err       <= (up_done || flush) && rx_fifo_full;
      if (up_done)    rx_fifo_data <= up_word;
      else if (flush) rx_fifo_data <= {pk_half[1], pk_half[0]};
      if (flush) begin
        pk_have <= 1'b0;
        for (int c = 0; c < NCH; c++) pk_half[c] <= '0;
      end else if (rx_packed) begin
        for (int c = 0; c < NCH; c++) begin
          if (r_done[c]) begin
            pk_half[c] <= r_word[c][HALF_W-1:0];
            pk_have    <= 1'b1;
          end
        end
      end
    end
  end

  AST_SDO_ONLY_ON_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !$past(drive_tick) |-> $stable(sdo)); // R3
  AST_POP_ON_DRIVE: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_pop |-> drive_tick); // R4
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_pop |-> !tx_fifo_empty); // R6
  AST_UNPACKED_PUSH_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (rx_fifo_push && !$past(rx_packed)) |-> $past(sample_tick)); // R7
  AST_PACKED_PUSH_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    (rx_fifo_push && $past(rx_packed)) |-> $past(frame_start)); // R8
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_fifo_push |-> !$past(rx_fifo_full)); // R9
  AST_PUSH_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rx_fifo_push && rx_err)); // R9
  AST_TICKS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(drive_tick && sample_tick)); // R12
  AST_FRAME_WITH_DRIVE: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> drive_tick); // R12
endmodule

// File: tb/pcm_pos_shifter_tb_top.sv
module pcm_pos_shifter_tb_top;
  logic        clk = 1'b0, rst = 1'b1;
  logic        drive_tick = 0, sample_tick = 0, frame_start = 0, sdi = 0;
  logic [9:0]  bit_idx = '0;
  logic [31:0] tx_cfg = '0, rx_cfg = '0;
  logic        tx_packed = 0, rx_packed = 0, rx_fifo_full = 0;
  logic [31:0] tx_fifo_data, rx_fifo_data;
  logic        tx_fifo_empty, tx_fifo_pop, sdo, rx_fifo_push, tx_err, rx_err;

  always #10 clk = ~clk; // 50 MHz

  pcm_pos_shifter dut_i (
    .clk(clk), .rst(rst), .drive_tick(drive_tick), .sample_tick(sample_tick),
    .frame_start(frame_start), .bit_idx(bit_idx), .tx_cfg(tx_cfg), .rx_cfg(rx_cfg),
    .tx_packed(tx_packed), .rx_packed(rx_packed), .tx_fifo_data(tx_fifo_data),
    .tx_fifo_empty(tx_fifo_empty), .tx_fifo_pop(tx_fifo_pop), .sdo(sdo), .sdi(sdi),
    .rx_fifo_full(rx_fifo_full), .rx_fifo_push(rx_fifo_push), .rx_fifo_data(rx_fifo_data),
    .tx_err(tx_err), .rx_err(rx_err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // transmit FIFO model
  logic [31:0] txq [0:255];
  int tx_head = 0, tx_tail = 0;
  assign tx_fifo_empty = (tx_head == tx_tail);
  assign tx_fifo_data  = txq[tx_head % 256];
  always @(posedge clk) if (tx_fifo_pop) tx_head <= tx_head + 1;

  // receive collector and error counters
  logic [31:0] rxgot [0:255];
  int ngot = 0, rxerr_cnt = 0, txerr_cnt = 0;
  always @(posedge clk) begin
    if (rx_fifo_push) begin rxgot[ngot % 256] <= rx_fifo_data; ngot <= ngot + 1; end
    if (rx_err) rxerr_cnt <= rxerr_cnt + 1;
    if (tx_err) txerr_cnt <= txerr_cnt + 1;
  end

  // channel model state
  int   cw [2], cp [2];
  bit   ce [2];
  bit   cpk;
  logic exp_sdo [0:1023];
  logic sdi_bits [0:1023];
  logic [31:0] rxexp [0:255];
  int   nexp, txerr_bit;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_half(input bit en, input int pos, input int w);
    bit ext;
    int code;
    ext  = (w >= 24);
    code = ext ? w - 24 : w - 8;
    return {ext, en, 10'(pos), 4'(code)};
  endfunction

  task automatic apply_cfg();
    tx_cfg = {mk_half(ce[0], cp[0], cw[0]), mk_half(ce[1], cp[1], cw[1])};
    rx_cfg = tx_cfg;
    tx_packed = cpk; rx_packed = cpk;
  endtask

  task automatic push_tx(input logic [31:0] w);
    txq[tx_tail % 256] = w;
    tx_tail++;
  endtask

  task automatic rand_sdi(input int fl);
    for (int b = 0; b < fl; b++) sdi_bits[b] = 1'($urandom);
  endtask

  // Expected sdo bits and receive words for one frame (R1..R5, R7, R8)
  task automatic expect_frame(input logic [31:0] wa, input logic [31:0] wb, input bit want_rx);
    int first, other;
    logic [31:0] tv [2];
    logic [31:0] rv [2];
    first = (cp[0] <= cp[1]) ? 0 : 1;
    if (!ce[0]) first = 1;
    if (!ce[1]) first = 0;
    other = 1 - first;
    for (int b = 0; b < 1024; b++) exp_sdo[b] = 1'b0;
    for (int c = 0; c < 2; c++) begin
      tv[c] = cpk ? {16'h0, wa[16*c +: 16]} : ((c == first) ? wa : wb);
      rv[c] = '0;
      if (ce[c]) begin
        for (int k = 0; k < cw[c]; k++) begin
          exp_sdo[cp[c] + k] = tv[c][cw[c] - 1 - k];
          rv[c] = {rv[c][30:0], sdi_bits[cp[c] + k]};
        end
      end
    end
    if (want_rx) begin
      if (cpk) begin
        if (ce[0] || ce[1]) begin rxexp[nexp] = {rv[1][15:0], rv[0][15:0]}; nexp++; end
      end else begin
        if (ce[first]) begin rxexp[nexp] = rv[first]; nexp++; end
        if (ce[other]) begin rxexp[nexp] = rv[other]; nexp++; end
      end
    end
  endtask

  // Tick pattern keeps drive and sample ticks apart, frame_start with drive (R12)
  task automatic run_frame(input int fl, output int mism);
    mism = 0;
    txerr_bit = -1;
    for (int b = 0; b < fl; b++) begin
      drive_tick = 1; bit_idx = 10'(b); frame_start = (b == 0);
      @(posedge clk); @(negedge clk);
      drive_tick = 0; frame_start = 0;
      if (sdo !== exp_sdo[b]) mism++;
      if (tx_err) txerr_bit = b;
      sample_tick = 1; sdi = sdi_bits[b];
      @(posedge clk); @(negedge clk);
      sample_tick = 0;
    end
  endtask

  task automatic flush_frame();
    drive_tick = 1; frame_start = 1; bit_idx = 10'h3FF;
    @(posedge clk); @(negedge clk);
    drive_tick = 0; frame_start = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check_rx(input int base, input string req);
    idle(2);
    chk((ngot - base) == nexp, req, "push count", 32'(ngot - base), 32'(nexp));
    for (int i = 0; i < nexp; i++)
      chk(rxgot[(base + i) % 256] === rxexp[i], req, "rx word",
          rxgot[(base + i) % 256], rxexp[i]);
  endtask

  initial begin
    int mism, base, h0, e0, fl;
    logic [31:0] wa, wb;
    void'($urandom(32'd1357));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    idle(1);

    // R11 reset state
    chk(sdo == 0 && tx_err == 0 && rx_err == 0, "R11", "sdo/err after reset",
        {29'b0, sdo, tx_err, rx_err}, 0);
    chk(rx_fifo_push == 0 && rx_fifo_data == 0, "R11", "rx push/data after reset",
        rx_fifo_data, 0);
    chk(tx_fifo_pop == 0, "R11", "no pop without tick", 32'(tx_fifo_pop), 0);

    // R2 clamp: extend with code 15 gives 39, used as 32
    tx_tail = tx_head; nexp = 0; base = ngot;
    ce[0] = 1; cp[0] = 3; cw[0] = 32; ce[1] = 0; cp[1] = 0; cw[1] = 8; cpk = 0;
    apply_cfg();
    tx_cfg[31:16] = {1'b1, 1'b1, 10'd3, 4'hF}; rx_cfg = tx_cfg;
    wa = 32'hC3A5_0F96; push_tx(wa); rand_sdi(40);
    expect_frame(wa, 0, 1);
    run_frame(40, mism);
    chk(mism == 0, "R2", "clamped width sdo mismatches", 32'(mism), 0);
    check_rx(base, "R2");

    // R6 underflow: second channel finds FIFO empty
    tx_tail = tx_head; nexp = 0; base = ngot; e0 = txerr_cnt;
    ce[0] = 1; cp[0] = 2; cw[0] = 12; ce[1] = 1; cp[1] = 20; cw[1] = 10; cpk = 0;
    apply_cfg();
    wa = 32'hFFFF_FABC; push_tx(wa); rand_sdi(34);
    for (int b = 20; b < 30; b++) sdi_bits[b] = 1'b1;
    expect_frame(wa, 0, 1);
    run_frame(34, mism);
    chk(mism == 0, "R6", "underflow zeros on sdo", 32'(mism), 0);
    chk(txerr_bit == 20, "R6", "tx_err bit index", 32'(txerr_bit), 20);
    idle(1);
    chk(txerr_cnt - e0 == 1, "R6", "tx_err pulse count", 32'(txerr_cnt - e0), 1);
    chk(tx_head == tx_tail, "R6", "pops while empty", 32'(tx_head), 32'(tx_tail));
    check_rx(base, "R7");

    // R9 overflow: full during the whole frame, both words dropped
    tx_tail = tx_head; nexp = 0; base = ngot; e0 = rxerr_cnt;
    ce[0] = 1; cp[0] = 0; cw[0] = 16; ce[1] = 1; cp[1] = 16; cw[1] = 16; cpk = 0;
    apply_cfg(); push_tx(32'h1234); push_tx(32'h5678); rand_sdi(34);
    expect_frame(32'h1234, 32'h5678, 0);
    rx_fifo_full = 1;
    run_frame(34, mism);
    idle(2);
    rx_fifo_full = 0;
    chk(ngot == base, "R9", "pushes while full", 32'(ngot - base), 0);
    chk(rxerr_cnt - e0 == 2, "R9", "rx_err pulses", 32'(rxerr_cnt - e0), 2);

    // R10 both channels disabled in packed mode
    tx_tail = tx_head; nexp = 0; base = ngot;
    ce[0] = 0; cp[0] = 0; cw[0] = 16; ce[1] = 0; cp[1] = 16; cw[1] = 16; cpk = 1;
    apply_cfg(); push_tx(32'hFFFF_FFFF); h0 = tx_head; rand_sdi(34);
    expect_frame(32'hFFFF_FFFF, 0, 1);
    run_frame(34, mism);
    idle(2);
    chk(mism == 0, "R10", "sdo with channels off", 32'(mism), 0);
    chk(tx_head == h0, "R10", "pops with channels off", 32'(tx_head - h0), 0);
    chk(ngot == base, "R10", "pushes with channels off", 32'(ngot - base), 0);

    // R1 far position and position 0, channel 2 first in the frame
    tx_tail = tx_head; nexp = 0; base = ngot;
    ce[0] = 1; cp[0] = 990; cw[0] = 32; ce[1] = 1; cp[1] = 0; cw[1] = 8; cpk = 0;
    apply_cfg(); push_tx(32'h0000_005A); push_tx(32'h8765_4321); rand_sdi(1024);
    expect_frame(32'h0000_005A, 32'h8765_4321, 1);
    run_frame(1024, mism);
    chk(mism == 0, "R1", "far/zero positions sdo", 32'(mism), 0);
    check_rx(base, "R1");

    // R8 packed with only channel 2 enabled: channel 1 half reads 0
    tx_tail = tx_head; nexp = 0; base = ngot;
    ce[0] = 0; cp[0] = 0; cw[0] = 16; ce[1] = 1; cp[1] = 5; cw[1] = 16; cpk = 1;
    apply_cfg(); push_tx(32'hBEEF_1111); rand_sdi(24);
    expect_frame(32'hBEEF_1111, 0, 1);
    run_frame(24, mism);
    chk(mism == 0, "R5", "packed channel 2 uses high half", 32'(mism), 0);
    flush_frame();
    check_rx(base, "R8");

    // random frames: R3, R4, R5, R7, R8
    for (int it = 0; it < 24; it++) begin
      int first, g0, g1, g2, pa, pb;
      tx_tail = tx_head; nexp = 0; base = ngot;
      cpk = (it % 3 == 2);
      for (int c = 0; c < 2; c++) begin
        ce[c] = 1;
        cw[c] = cpk ? 8 + int'($urandom % 9) : 8 + int'($urandom % 25);
      end
      first = int'($urandom % 2);
      g0 = int'($urandom % 4); g1 = int'($urandom % 4); g2 = 1 + int'($urandom % 4);
      pa = g0; pb = g0 + cw[first] + g1;
      cp[first] = pa; cp[1 - first] = pb;
      fl = pb + cw[1 - first] + g2;
      apply_cfg();
      for (int f = 0; f < 2; f++) begin
        wa = $urandom; wb = $urandom;
        push_tx(wa);
        if (!cpk) push_tx(wb);
        rand_sdi(fl);
        expect_frame(wa, wb, 1);
        run_frame(fl, mism);
        chk(mism == 0, cpk ? "R5" : "R3", "random frame sdo mismatches", 32'(mism), 0);
      end
      chk(tx_head == tx_tail, "R4", "words consumed", 32'(tx_head), 32'(tx_tail));
      flush_frame();
      check_rx(base, cpk ? "R8" : "R7");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule